// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the storage and transfer half of a small accumulator machine. Six registers and a word memory sit around one shared data bus. A 3-bit source code picks the single source that drives the bus in a cycle. Each register has its own capture, count-up and zeroing controls, which a separate sequencer drives. On a clock edge a register can take the bus value, add one to itself, or clear itself.

Two registers hold addresses and are narrower than the bus. When one of them drives the bus, its value is zero-filled at the top. When one of them captures from the bus, it keeps only the low bits. The memory is always addressed by the address register. It can place the addressed word on the bus, and it can store the current bus word at that address on a clock edge.

The accumulator does not capture from the bus. It takes its new value from a separate result port, which an arithmetic unit outside this block drives.

Top module: `cbus_datapath`

## Requirements
- R1: Source codes 1 to 6 place the address register, program counter, data register, accumulator, instruction register and temporary register on the bus in the same cycle, in that order of codes. When the 12-bit address register or program counter drives the bus, bus bits 15 to 12 read zero.
- R2: Source code 0 drives an all-zero bus.
- R3: Source code 7 with the memory read strobe high drives the memory word at the address register onto the bus. With the read strobe low, code 7 drives zero.
- R4: A register whose load control is high captures the bus on the next rising edge. The address register and program counter keep only bus bits 11 to 0.
- R5: The accumulator load captures the external result port, not the bus.
- R6: Increment adds one modulo the register width, so 0xFFF wraps to 0x000 in a 12-bit register and 0xFFFF wraps to 0x0000 in a 16-bit register.
- R7: Clear sets a register to zero. When controls are raised together, clear wins over load, and load wins over increment. The instruction register has a load control only.
- R8: A register with none of its controls high keeps its value, whatever the bus carries.
- R9: A high write strobe stores the bus word at the address held in the address register on the rising edge. Each address keeps its own word.
- R10: An active-low asynchronous reset clears all six registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source code |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| ar_ld | input | 1 | Address register load |
| ar_inc | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load |
| pc_inc | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load |
| dr_inc | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| ac_ld | input | 1 | Accumulator load from result port |
| ac_inc | input | 1 | Accumulator increment |
| ac_clr | input | 1 | Accumulator clear |
| ir_ld | input | 1 | Instruction register load |
| tr_ld | input | 1 | Temporary register load |
| tr_inc | input | 1 | Temporary register increment |
| tr_clr | input | 1 | Temporary register clear |
| alu_result | input | 16 | New accumulator value from the external unit |
| bus_out | output | 16 | Current bus word |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The bench builds the block with its default widths: a 12-bit address path, a 16-bit bus and 4096 memory words. These defaults make the exact four-bit zero fill visible. They also let the bench check the wrap from 0xFFF to 0x000 and reach the top and bottom memory addresses. Arbitrary 16-bit words enter the datapath through the result port and are then spread over the bus. This shows that the narrow registers drop the upper bits, and it lets the bench test priority with every control raised at once on one register.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_ADDR = 3'd1,
        SRC_PROG = 3'd2,
        SRC_DATA = 3'd3,
        SRC_ACCU = 3'd4,
        SRC_INSN = 3'd5,
        SRC_TEMP = 3'd6,
        SRC_MEM  = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_INCR  = 2'd3
    } reg_op_e;

endpackage

// File: rtl/cbus_reg.sv
module cbus_reg
    import cbus_pkg::*;
#(
    parameter int W       = 16,
    parameter bit HAS_INC = 1'b1,
    parameter bit HAS_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic    inc_en;
    logic    clr_en;
    reg_op_e op;

    generate
        if (HAS_INC) begin : g_inc
            assign inc_en = inc;
        end else begin : g_no_inc
            assign inc_en = 1'b0 & inc;
        end
        if (HAS_CLR) begin : g_clr
            assign clr_en = clr;
        end else begin : g_no_clr
            assign clr_en = 1'b0 & clr;
        end
    endgenerate

    // priority: clear, then load, then increment
    always_comb begin
        if (clr_en)      op = OP_CLEAR;
        else if (ld)     op = OP_LOAD;
        else if (inc_en) op = OP_INCR;
        else             op = OP_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= d;
                OP_INCR:  q <= q + W'(1);
                OP_HOLD:  q <= q;
            endcase
        end
    end

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CLR && clr) |=> (q == '0));

    p_load_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !(HAS_CLR && clr)) |=> (q == $past(d)));

    p_incr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_INC && inc && !ld && !(HAS_CLR && clr)) |=> (q == $past(q) + W'(1)));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !(HAS_INC && inc) && !(HAS_CLR && clr)) |=> $stable(q));

endmodule

// File: rtl/cbus_mem.sv
module cbus_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = re ? store[addr] : '0;

endmodule

// File: rtl/cbus_mux.sv
module cbus_mux
    import cbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] ar,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] dr,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] ir,
    input  logic [DATA_W-1:0] tr,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] bus
);

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ar_wide;
    logic [DATA_W-1:0] pc_wide;

    assign ar_wide = {{PAD_W{1'b0}}, ar};
    assign pc_wide = {{PAD_W{1'b0}}, pc};

    always_comb begin
        unique case (src_e'(sel))
            SRC_NONE: bus = '0;
            SRC_ADDR: bus = ar_wide;
            SRC_PROG: bus = pc_wide;
            SRC_DATA: bus = dr;
            SRC_ACCU: bus = ac;
            SRC_INSN: bus = ir;
            SRC_TEMP: bus = tr;
            SRC_MEM:  bus = mem;
        endcase
    end

endmodule

// File: rtl/cbus_datapath.sv
module cbus_datapath
    import cbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_sel,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              ar_ld,
    input  logic              ar_inc,
    input  logic              ar_clr,
    input  logic              pc_ld,
    input  logic              pc_inc,
    input  logic              pc_clr,
    input  logic              dr_ld,
    input  logic              dr_inc,
    input  logic              dr_clr,
    input  logic              ac_ld,
    input  logic              ac_inc,
    input  logic              ac_clr,
    input  logic              ir_ld,
    input  logic              tr_ld,
    input  logic              tr_inc,
    input  logic              tr_clr,
    input  logic [DATA_W-1:0] alu_result,
    output logic [DATA_W-1:0] bus_out,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] dr_q,
    output logic [DATA_W-1:0] ac_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] tr_q
);

    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] bus_low;

    assign bus_low = bus[ADDR_W-1:0];

    cbus_reg #(.W(ADDR_W), .HAS_INC(1'b1), .HAS_CLR(1'b1)) u_ar (
        .clk(clk), .rst_n(rst_n), .ld(ar_ld), .inc(ar_inc), .clr(ar_clr),
        .d(bus_low), .q(ar_q));

    cbus_reg #(.W(ADDR_W), .HAS_INC(1'b1), .HAS_CLR(1'b1)) u_pc (
        .clk(clk), .rst_n(rst_n), .ld(pc_ld), .inc(pc_inc), .clr(pc_clr),
        .d(bus_low), .q(pc_q));

    cbus_reg #(.W(DATA_W), .HAS_INC(1'b1), .HAS_CLR(1'b1)) u_dr (
        .clk(clk), .rst_n(rst_n), .ld(dr_ld), .inc(dr_inc), .clr(dr_clr),
        .d(bus), .q(dr_q));

    cbus_reg #(.W(DATA_W), .HAS_INC(1'b1), .HAS_CLR(1'b1)) u_ac (
        .clk(clk), .rst_n(rst_n), .ld(ac_ld), .inc(ac_inc), .clr(ac_clr),
        .d(alu_result), .q(ac_q));

    cbus_reg #(.W(DATA_W), .HAS_INC(1'b0), .HAS_CLR(1'b0)) u_ir (
        .clk(clk), .rst_n(rst_n), .ld(ir_ld), .inc(1'b0), .clr(1'b0),
        .d(bus), .q(ir_q));

    cbus_reg #(.W(DATA_W), .HAS_INC(1'b1), .HAS_CLR(1'b1)) u_tr (
        .clk(clk), .rst_n(rst_n), .ld(tr_ld), .inc(tr_inc), .clr(tr_clr),
        .d(bus), .q(tr_q));

    cbus_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .addr(ar_q), .wdata(bus), .we(mem_wr), .re(mem_rd),
        .rdata(mem_rdata));

    cbus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
        .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus));

    assign bus_out = bus;

    p_addr_zero_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SRC_ADDR || bus_sel == SRC_PROG) |-> (bus[DATA_W-1:ADDR_W] == '0));

    p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SRC_NONE) |-> (bus == '0));

    p_mem_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SRC_MEM && !mem_rd) |-> (bus == '0));

    p_acc_from_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_ld && !ac_clr) |=> (ac_q == $past(alu_result)));

endmodule

// File: tb/cbus_datapath_tb.sv
`timescale 1ns/1ps
module cbus_datapath_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic        mem_rd = 0, mem_wr = 0;
    logic        ar_ld = 0, ar_inc = 0, ar_clr = 0;
    logic        pc_ld = 0, pc_inc = 0, pc_clr = 0;
    logic        dr_ld = 0, dr_inc = 0, dr_clr = 0;
    logic        ac_ld = 0, ac_inc = 0, ac_clr = 0;
    logic        ir_ld = 0;
    logic        tr_ld = 0, tr_inc = 0, tr_clr = 0;
    logic [15:0] alu_result = 16'h0;
    logic [15:0] bus_out;
    logic [11:0] ar_q, pc_q;
    logic [15:0] dr_q, ac_q, ir_q, tr_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cbus_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ar_ld(ar_ld), .ar_inc(ar_inc), .ar_clr(ar_clr),
        .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr),
        .dr_ld(dr_ld), .dr_inc(dr_inc), .dr_clr(dr_clr),
        .ac_ld(ac_ld), .ac_inc(ac_inc), .ac_clr(ac_clr),
        .ir_ld(ir_ld), .tr_ld(tr_ld), .tr_inc(tr_inc), .tr_clr(tr_clr),
        .alu_result(alu_result), .bus_out(bus_out),
        .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q));

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 3'd0; mem_rd = 0; mem_wr = 0;
        ar_ld = 0; ar_inc = 0; ar_clr = 0; pc_ld = 0; pc_inc = 0; pc_clr = 0;
        dr_ld = 0; dr_inc = 0; dr_clr = 0; ac_ld = 0; ac_inc = 0; ac_clr = 0;
        ir_ld = 0; tr_ld = 0; tr_inc = 0; tr_clr = 0;
    endtask

    // one edge, then settle away from it with controls dropped
    task automatic tick();
        @(posedge clk);
        #2;
        idle();
        #1;
    endtask

    task automatic set_ac(input logic [15:0] v);
        alu_result = v; ac_ld = 1; tick();
    endtask

    task automatic set_ar(input logic [15:0] v);
        set_ac(v); bus_sel = 3'd4; ar_ld = 1; tick();
    endtask

    task automatic t_reset();
        check("R10 ar", {4'h0, ar_q}, 16'h0);
        check("R10 pc", {4'h0, pc_q}, 16'h0);
        check("R10 dr", dr_q, 16'h0);
        check("R10 ac", ac_q, 16'h0);
        check("R10 ir", ir_q, 16'h0);
        check("R10 tr", tr_q, 16'h0);
        check("R2 idle bus", bus_out, 16'h0);
    endtask

    task automatic t_spread();
        set_ac(16'hABCD);
        check("R5 ac from result", ac_q, 16'hABCD);
        bus_sel = 3'd4; #1;
        check("R1 code4 ac", bus_out, 16'hABCD);
        ar_ld = 1; pc_ld = 1; dr_ld = 1; ir_ld = 1; tr_ld = 1; tick();
        check("R4 ar low bits", {4'h0, ar_q}, 16'h0BCD);
        check("R4 pc low bits", {4'h0, pc_q}, 16'h0BCD);
        check("R4 dr", dr_q, 16'hABCD);
        check("R4 ir", ir_q, 16'hABCD);
        check("R4 tr", tr_q, 16'hABCD);
        bus_sel = 3'd1; #1; check("R1 code1 ar zero fill", bus_out, 16'h0BCD);
        bus_sel = 3'd2; #1; check("R1 code2 pc zero fill", bus_out, 16'h0BCD);
        bus_sel = 3'd3; #1; check("R1 code3 dr", bus_out, 16'hABCD);
        bus_sel = 3'd5; #1; check("R1 code5 ir", bus_out, 16'hABCD);
        bus_sel = 3'd6; #1; check("R1 code6 tr", bus_out, 16'hABCD);
        bus_sel = 3'd0; #1; check("R2 code0 zero", bus_out, 16'h0);
        idle();
    endtask

    task automatic t_acc_ignores_bus();
        // bus carries DR (ABCD) while the result port carries 1357
        alu_result = 16'h1357; bus_sel = 3'd3; ac_ld = 1; tick();
        check("R5 ac ignores bus", ac_q, 16'h1357);
    endtask

    task automatic t_memory();
        set_ar(16'h0010);
        set_ac(16'h1234); bus_sel = 3'd4; mem_wr = 1; tick();
        set_ar(16'h0FFF);
        set_ac(16'h5678); bus_sel = 3'd4; mem_wr = 1; tick();
        set_ar(16'h0000);
        set_ac(16'h9ABC); bus_sel = 3'd4; mem_wr = 1; tick();
        set_ar(16'h0010);
        bus_sel = 3'd7; mem_rd = 1; #1;
        check("R9 word at 0x010", bus_out, 16'h1234);
        check("R3 read strobe", bus_out, 16'h1234);
        mem_rd = 0; #1;
        check("R3 no strobe zero", bus_out, 16'h0);
        idle();
        set_ar(16'h0FFF);
        bus_sel = 3'd7; mem_rd = 1; #1;
        check("R9 word at 0xFFF", bus_out, 16'h5678);
        idle();
        set_ar(16'h0000);
        bus_sel = 3'd7; mem_rd = 1; #1;
        check("R9 word at 0x000", bus_out, 16'h9ABC);
        // read into DR via bus
        dr_ld = 1; tick();
        check("R3 dr from memory", dr_q, 16'h9ABC);
    endtask

    task automatic t_increment();
        set_ac(16'hFFFF);
        bus_sel = 3'd4; pc_ld = 1; ar_ld = 1; dr_ld = 1; tick();
        check("R4 pc 0xFFF", {4'h0, pc_q}, 16'h0FFF);
        pc_inc = 1; ar_inc = 1; ac_inc = 1; dr_inc = 1; tick();
        check("R6 pc wrap", {4'h0, pc_q}, 16'h0000);
        check("R6 ar wrap", {4'h0, ar_q}, 16'h0000);
        check("R6 ac wrap", ac_q, 16'h0000);
        check("R6 dr wrap", dr_q, 16'h0000);
        set_ac(16'h0005); bus_sel = 3'd4; tr_ld = 1; tick();
        tr_inc = 1; tick();
        check("R6 tr 5 to 6", tr_q, 16'h0006);
    endtask

    task automatic t_priority();
        set_ac(16'h4321);
        bus_sel = 3'd4; tr_ld = 1; tr_inc = 1; tr_clr = 1; tick();
        check("R7 clear wins", tr_q, 16'h0000);
        bus_sel = 3'd4; tr_ld = 1; tr_inc = 1; tick();
        check("R7 load over inc", tr_q, 16'h4321);
        alu_result = 16'h7777; ac_ld = 1; ac_clr = 1; ac_inc = 1; tick();
        check("R7 ac clear wins", ac_q, 16'h0000);
        pc_clr = 1; ar_clr = 1; tick();
        check("R7 pc clear", {4'h0, pc_q}, 16'h0);
        check("R7 ar clear", {4'h0, ar_q}, 16'h0);
    endtask

    task automatic t_hold();
        set_ac(16'h2468);
        bus_sel = 3'd4; ir_ld = 1; tick();
        set_ac(16'h1111);
        bus_sel = 3'd4; tick();
        check("R8 ir hold", ir_q, 16'h2468);
        check("R8 tr hold", tr_q, 16'h4321);
        bus_sel = 3'd5; #1;
        check("R8 ir on bus", bus_out, 16'h2468);
        idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        idle();
        #23;
        t_reset();
        rst_n = 1'b1;
        #10;
        t_spread();
        t_acc_ignores_bus();
        t_memory();
        t_increment();
        t_priority();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule